// File: doc/BRIEF.md
# Saturating Add/Subtract Execution Unit

This unit executes four signed 32-bit saturating operations taken from an instruction word: a plain add, a plain subtract, and doubled forms in which the second operand is multiplied by two before the add or subtract. The register file sits outside the unit. It shows the two source register indices decoded from the instruction and takes the operand values supplied back to it. After one clock it returns a result, the destination index and a destination write-enable.

A condition field in the instruction gates execution. One code value always executes. Any other value executes only when an external condition-pass input is high, because full flag evaluation belongs to the surrounding pipeline. Any saturation, at the doubling step or at the final step, sets a sticky flag. Only a synchronous clear input or reset returns the flag to zero.

Top module: `sat_alu_unit`

## Requirements
- R1: Instruction bits 22:21 select the operation: 0 add, 1 subtract, 2 doubled add, 3 doubled subtract. Add yields Rm + Rn, where Rm is the value on `rm_val_i` and Rn is the value on `rn_val_i`.
- R2: Subtract yields Rm - Rn.
- R3: A signed overflow in a step replaces that step's output. The replacement is 0x7FFFFFFF when the wrapped sum or difference has bit 31 set, and 0x80000000 when bit 31 is clear.
- R4: Doubled forms first saturate 2 x Rn. They then add that saturated value to Rm or subtract it from Rm, and saturate again.
- R5: `rm_idx_o` equals instruction bits 3:0 and `rn_idx_o` equals bits 19:16, both combinationally. `rd_idx_o` takes bits 15:12 of the executed instruction.
- R6: A condition field (bits 31:28) of 0xE executes unconditionally. Any other value executes only while `cond_pass_i` is 1.
- R7: `valid_o`, `rd_we_o`, `result_o` and `rd_idx_o` reflect an accepted input one clock after `valid_i`. All are 0 after reset.
- R8: A valid instruction whose condition fails leaves `rd_we_o` at 0, holds `result_o` and does not change the flag.
- R9: Any saturation of an executed instruction, whether at the intermediate or the final step, sets `sat_flag_o`. The flag stays 1 until it is cleared.
- R10: `sat_clr_i` clears the flag at the next clock. If a saturating instruction executes in the same cycle, the flag ends at 1. Reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands present |
| instr_i | input | 32 | Instruction word |
| rm_val_i | input | 32 | Value of the first source register (Rm) |
| rn_val_i | input | 32 | Value of the second source register (Rn) |
| cond_pass_i | input | 1 | External condition result |
| sat_clr_i | input | 1 | Synchronous clear of the sticky flag |
| rm_idx_o | output | 4 | Rm register index |
| rn_idx_o | output | 4 | Rn register index |
| valid_o | output | 1 | Registered valid |
| rd_we_o | output | 1 | Destination write-enable |
| rd_idx_o | output | 4 | Destination register index |
| result_o | output | 32 | Saturated result |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach is a doubled instruction where only the doubling step saturates. The final step must then use the clamped value and must not clamp again. The stimulus reaches this case with Rn near a quarter of the range and an Rm of the opposite sign. With those operands the saturated and the wrapped intermediate give different results, and the flag must still rise. The bench clears the flag before every table vector, so each vector shows its own saturation event. Directed cases then cover a clear and a saturation in the same cycle, and a failing condition with saturating operands.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 4;
  localparam int COND_W  = 4;
  localparam int COND_LO = 28;
  localparam int OP_LO   = 21;
  localparam int RN_LO   = 16;
  localparam int RD_LO   = 12;
  localparam int RM_LO   = 0;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_DADD = 2'd2,
    OP_DSUB = 2'd3
  } sat_op_e;

  typedef struct packed {
    logic [COND_W-1:0] cond;
    sat_op_e           op;
    logic [IDX_W-1:0]  rn;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  rm;
  } sat_fields_t;
endpackage

// File: rtl/sat_decode.sv
module sat_decode
  import sat_pkg::*;
(
  input  logic [DATA_W-1:0] instr_i,
  input  logic              valid_i,
  input  logic              cond_pass_i,
  output sat_fields_t       fields_o,
  output logic              exec_o
);
  always_comb begin
    fields_o.cond = instr_i[COND_LO +: COND_W];
    fields_o.op   = sat_op_e'(instr_i[OP_LO +: 2]);
    fields_o.rn   = instr_i[RN_LO +: IDX_W];
    fields_o.rd   = instr_i[RD_LO +: IDX_W];
    fields_o.rm   = instr_i[RM_LO +: IDX_W];
  end

  assign exec_o = valid_i && ((fields_o.cond == COND_ALWAYS) || cond_pass_i);
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         ovf;

  always_comb begin
    raw = sub_i ? (a_i - b_i) : (a_i + b_i);
    // add: like signs in; sub: unlike signs in; then result sign departs from a
    ovf = ((a_i[W-1] ^ b_i[W-1]) == sub_i) && (raw[W-1] != a_i[W-1]);
    y_o   = ovf ? (raw[W-1] ? MAX_POS : MIN_NEG) : raw;
    sat_o = ovf;
  end
endmodule

// File: rtl/sat_alu_unit.sv
module sat_alu_unit
  import sat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic [DATA_W-1:0] rn_val_i,
  input  logic              cond_pass_i,
  input  logic              sat_clr_i,
  output logic [IDX_W-1:0]  rm_idx_o,
  output logic [IDX_W-1:0]  rn_idx_o,
  output logic              valid_o,
  output logic              rd_we_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic              sat_flag_o
);
  sat_fields_t       fld;
  logic              exec;
  logic [DATA_W-1:0] dbl_y, fin_b, fin_y;
  logic              dbl_sat, fin_sat, sat_evt;

  sat_decode u_dec (
    .instr_i    (instr_i),
    .valid_i    (valid_i),
    .cond_pass_i(cond_pass_i),
    .fields_o   (fld),
    .exec_o     (exec)
  );

  assign rm_idx_o = fld.rm;
  assign rn_idx_o = fld.rn;

  // doubling stage: Rn + Rn, clamped
  sat_addsub #(.W(DATA_W)) u_dbl (
    .sub_i(1'b0),
    .a_i  (rn_val_i),
    .b_i  (rn_val_i),
    .y_o  (dbl_y),
    .sat_o(dbl_sat)
  );

  assign fin_b = fld.op[1] ? dbl_y : rn_val_i;

  sat_addsub #(.W(DATA_W)) u_fin (
    .sub_i(fld.op[0]),
    .a_i  (rm_val_i),
    .b_i  (fin_b),
    .y_o  (fin_y),
    .sat_o(fin_sat)
  );

  assign sat_evt = fin_sat || (fld.op[1] && dbl_sat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      rd_we_o    <= 1'b0;
      rd_idx_o   <= '0;
      result_o   <= '0;
      sat_flag_o <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      rd_we_o    <= exec;
      if (exec) begin
        result_o <= fin_y;
        rd_idx_o <= fld.rd;
      end
      // set wins over clear in the same cycle
      sat_flag_o <= (sat_flag_o && !sat_clr_i) || (exec && sat_evt);
    end
  end

  assert_we_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> valid_o);

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_flag_o && !sat_clr_i) |=> sat_flag_o);

  assert_evt_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && (dbl_sat || fin_sat) && (fld.op[1] || fin_sat)) |=> sat_flag_o);

  assert_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_clr_i && !exec) |=> !sat_flag_o);

  assert_skip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !exec && !sat_clr_i) |=> ($stable(sat_flag_o) && $stable(result_o) && !rd_we_o));
endmodule

// File: tb/sim_sat_alu_unit.sv
`timescale 1ns/1ps
module sim_sat_alu_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid, cond_pass, clr;
  logic [31:0] instr, rm_v, rn_v;
  logic [3:0]  rm_idx, rn_idx, rd_idx;
  logic        valid_q, we, flag;
  logic [31:0] res;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sat_alu_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .rm_val_i(rm_v), .rn_val_i(rn_v), .cond_pass_i(cond_pass), .sat_clr_i(clr),
    .rm_idx_o(rm_idx), .rn_idx_o(rn_idx), .valid_o(valid_q), .rd_we_o(we),
    .rd_idx_o(rd_idx), .result_o(res), .sat_flag_o(flag)
  );

  // {op, rm, rn, expected result, expected flag}
  localparam logic [98:0] VEC [16] = '{
    {2'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0},
    {2'd0, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
    {2'd0, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1},
    {2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b0},
    {2'd1, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0},
    {2'd1, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1},
    {2'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1},
    {2'd1, 32'h00000000, 32'h80000000, 32'h7FFFFFFF, 1'b1},
    {2'd2, 32'h0000000A, 32'h00000003, 32'h00000010, 1'b0},
    {2'd2, 32'h00000000, 32'h40000000, 32'h7FFFFFFF, 1'b1},
    {2'd2, 32'hFFFFFFFF, 32'h40000000, 32'h7FFFFFFE, 1'b1},
    {2'd2, 32'h00000001, 32'h3FFFFFFF, 32'h7FFFFFFF, 1'b0},
    {2'd2, 32'h0000000A, 32'hFFFFFFFB, 32'h00000000, 1'b0},
    {2'd3, 32'h00000000, 32'hC0000000, 32'h7FFFFFFF, 1'b1},
    {2'd3, 32'h00000005, 32'h00000002, 32'h00000001, 1'b0},
    {2'd3, 32'hFFFFFFFF, 32'hA0000000, 32'h7FFFFFFF, 1'b1}
  };

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [1:0] op,
                                     input logic [3:0] rn, input logic [3:0] rd,
                                     input logic [3:0] rm);
    mk = {c, 5'b00010, op, 1'b0, rn, rd, 8'h05, rm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, one clock, sample at the next negedge
  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input logic cp, input logic cl);
    @(negedge clk);
    valid = v; instr = ins; rm_v = a; rn_v = b; cond_pass = cp; clr = cl;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0; cond_pass = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    valid = 0; instr = '0; rm_v = '0; rn_v = '0; cond_pass = 0; clr = 0;
    repeat (3) @(negedge clk);
    // R7 / R10 reset state
    chk("R7 reset valid", {31'd0, valid_q}, 32'd0);
    chk("R7 reset we", {31'd0, we}, 32'd0);
    chk("R7 reset result", res, 32'd0);
    chk("R10 reset flag", {31'd0, flag}, 32'd0);
    rst_n = 1'b1;

    // R5 combinational source indices
    instr = mk(4'hE, 2'd0, 4'h9, 4'h4, 4'h6);
    #1;
    chk("R5 rm idx", {28'd0, rm_idx}, 32'h6);
    chk("R5 rn idx", {28'd0, rn_idx}, 32'h9);

    // R1 R2 R3 R4 R9 table
    for (int i = 0; i < 16; i++) begin
      logic [1:0]  op;
      logic [31:0] a, b, er;
      logic        ef;
      {op, a, b, er, ef} = VEC[i];
      step(1'b0, '0, '0, '0, 1'b0, 1'b1);
      step(1'b1, mk(4'hE, op, 4'h2, 4'(i), 4'h3), a, b, 1'b0, 1'b0);
      chk($sformatf("R1 R2 R3 R4 result vec%0d", i), res, er);
      chk($sformatf("R9 flag vec%0d", i), {31'd0, flag}, {31'd0, ef});
      chk($sformatf("R7 we vec%0d", i), {30'd0, valid_q, we}, 32'd3);
      chk($sformatf("R5 rd idx vec%0d", i), {28'd0, rd_idx}, i);
    end

    // R7 idle cycle after accepted input
    step(1'b0, '0, '0, '0, 1'b0, 1'b0);
    chk("R7 idle valid/we", {30'd0, valid_q, we}, 32'd0);

    // R8 condition fails with saturating operands
    step(1'b0, '0, '0, '0, 1'b0, 1'b1);
    step(1'b1, mk(4'hE, 2'd0, 4'h1, 4'h7, 4'h1), 32'd20, 32'd22, 1'b0, 1'b0);
    chk("R8 setup result", res, 32'd42);
    step(1'b1, mk(4'h0, 2'd0, 4'h1, 4'h8, 4'h1), 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0);
    chk("R8 we low", {31'd0, we}, 32'd0);
    chk("R8 result held", res, 32'd42);
    chk("R8 flag unchanged", {31'd0, flag}, 32'd0);
    chk("R8 rd idx held", {28'd0, rd_idx}, 32'h7);

    // R6 non-always condition with pass high executes
    step(1'b1, mk(4'h0, 2'd1, 4'h1, 4'hB, 4'h1), 32'd9, 32'd4, 1'b1, 1'b0);
    chk("R6 cond pass we", {31'd0, we}, 32'd1);
    chk("R6 cond pass result", res, 32'd5);

    // R9 sticky across a non-saturating op
    step(1'b1, mk(4'hE, 2'd0, 4'h1, 4'h1, 4'h1), 32'h7FFFFFFF, 32'd5, 1'b0, 1'b0);
    chk("R9 set", {31'd0, flag}, 32'd1);
    step(1'b1, mk(4'hE, 2'd0, 4'h1, 4'h1, 4'h1), 32'd1, 32'd1, 1'b0, 1'b0);
    chk("R9 sticky", {31'd0, flag}, 32'd1);
    step(1'b0, '0, '0, '0, 1'b0, 1'b0);
    chk("R9 sticky idle", {31'd0, flag}, 32'd1);

    // R10 clear, then clear together with saturation
    step(1'b0, '0, '0, '0, 1'b0, 1'b1);
    chk("R10 clear", {31'd0, flag}, 32'd0);
    step(1'b1, mk(4'hE, 2'd0, 4'h1, 4'h1, 4'h1), 32'd3, 32'd3, 1'b0, 1'b0);
    step(1'b1, mk(4'hE, 2'd2, 4'h1, 4'h1, 4'h1), 32'd0, 32'h50000000, 1'b0, 1'b1);
    chk("R10 set wins over clear", {31'd0, flag}, 32'd1);
    chk("R4 R10 result", res, 32'h7FFFFFFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule